// File: doc/BRIEF.md
# Harmonic Weighted Round-Robin Class Scheduler

This block is the upper tier of a two-level, criticality-aware arbiter for a shared memory bus. It walks through a repeating sequence of class slots and decides, for each slot, which criticality class owns the bus. Every class has a weight and a window size. The weight sets how often the class is re-armed. The window size sets how many consecutive task slots the class holds once it wins a class slot. The lower tier takes the granted class index and window and shares those task slots among the tasks of that class. When the window is used up, the lower tier pulses `slot_done_i` to move the schedule forward.

A load strobe captures the weights and windows. A serial divider then computes each class period (schedule length divided by weight) once, so no division runs in the cycle-by-cycle path. While the periods are being computed the schedule is held stopped. It then starts at class slot 0. A parameter set that cannot form a harmonic schedule is reported on `cfg_err_o` and the schedule stays stopped. Class 0 is the most critical. A weight of 0 removes a class from the schedule.

Top module: `class_slot_sched`

## Requirements
- R1: The schedule length H is the sum of all class weights. `slot_idx_o` counts 0 to H-1 and then wraps to 0. `hyper_start_o` is high for exactly one cycle: the first cycle after a wrap from H-1 back to 0.
- R2: A class with non-zero weight w is re-armed whenever the slot index is a multiple of H/w. Its armed state persists across slots until the class is granted.
- R3: In each slot, the grant goes to the armed class with the lowest index (class 0 is the most critical). The granted class is then disarmed when the slot advances.
- R4: At most one class is granted per slot. `grant_class_o` is less than the class count, and `grant_window_o` equals the granted class's configured window size.
- R5: While `grant_valid_o` is high, the slot index and the grant hold until `slot_done_i` is sampled high. The slot then advances on that edge.
- R6: When no class is armed, `grant_valid_o` is low, the slot advances after one cycle, and `slot_done_i` has no effect.
- R7: `cfg_err_o` is raised and the schedule stays stopped (`active_o` and `grant_valid_o` low) in any of these cases:
  - H is 0 or does not fit SLOT_W bits;
  - a non-zero weight does not divide H;
  - a weight has bits at or above SLOT_W;
  - an enabled class has a window of 0 or one that does not fit WIN_W bits.
- R8: A class with weight 0 is never granted.
- R9: After `cfg_load_i`, `active_o` and `grant_valid_o` are low until the periods are computed. The schedule then starts at slot 0 with no pulse on `hyper_start_o`.
- R10: After reset, `active_o`, `grant_valid_o`, `hyper_start_o` and `cfg_err_o` are low, and `slot_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Capture weights and windows; restart period computation |
| weight_cfg_i | input | N_CLASS*CFG_W | Per-class weight registers, class 0 in the low word |
| window_cfg_i | input | N_CLASS*CFG_W | Per-class window size registers |
| slot_done_i | input | 1 | Lower tier has used up the current window |
| grant_valid_o | output | 1 | A class owns the current slot |
| grant_class_o | output | CLS_W | Index of the granted class |
| grant_window_o | output | WIN_W | Task slots in the granted window |
| slot_idx_o | output | SLOT_W | Current class slot index |
| hyper_start_o | output | 1 | First cycle of a new schedule repetition |
| active_o | output | 1 | Schedule is running with a valid parameter set |
| cfg_err_o | output | 1 | Loaded parameter set is not schedulable |

## Verification
The bound properties assume that `slot_done_i` is only meaningful while a grant is shown. They also assume that, once `active_o` is high, H is a non-zero harmonic sum, because the block refuses to run any other parameter set. The stimulus always issues a load before it expects a running schedule. It then drives `slot_done_i` in one of two ways: exactly after the granted window's cycle count, or as a random strobe that also lands on idle slots. In both cases the bench only compares against a model that applies the modulo re-arm rule to integer slot numbers.

// File: rtl/class_slot_sched_pkg.sv
package class_slot_sched_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_SUM,
    CFG_DIV_GO,
    CFG_DIV_WAIT,
    CFG_DONE
  } cfg_state_e;
endpackage

// File: rtl/sched_serial_div.sv
module sched_serial_div #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     q_q, d_q;
  logic [W:0]       r_q;
  logic [W:0]       trial;

  assign trial = {r_q[W-1:0], q_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
      q_q    <= '0;
      d_q    <= '0;
      r_q    <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_o <= 1'b0;
      cnt_q  <= CNT_W'(W);
      q_q    <= dividend_i;
      d_q    <= divisor_i;
      r_q    <= '0;
    end else if (busy_q) begin
      if (trial >= {1'b0, d_q}) begin
        r_q <= trial - {1'b0, d_q};
        q_q <= {q_q[W-2:0], 1'b1};
      end else begin
        r_q <= trial;
        q_q <= {q_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = q_q;
  assign rem_o  = r_q[W-1:0];
endmodule

// File: rtl/sched_cfg_calc.sv
module sched_cfg_calc
  import class_slot_sched_pkg::*;
#(
  parameter int N_CLASS = 5,
  parameter int CFG_W   = 32,
  parameter int SLOT_W  = 12,
  parameter int WIN_W   = 8,
  parameter int CLS_W   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [N_CLASS-1:0][CFG_W-1:0]   weight_i,
  input  logic [N_CLASS-1:0][CFG_W-1:0]   window_i,
  output logic                            ok_o,
  output logic                            err_o,
  output logic [SLOT_W-1:0]               hyper_len_o,
  output logic [N_CLASS-1:0][SLOT_W-1:0]  period_o,
  output logic [N_CLASS-1:0]              en_o,
  output logic [N_CLASS-1:0][WIN_W-1:0]   window_o
);
  localparam int SUM_W = SLOT_W + $clog2(N_CLASS) + 1;

  cfg_state_e                     state_q;
  logic [CLS_W-1:0]               cls_q;
  logic [N_CLASS-1:0][SLOT_W-1:0] w_q;
  logic [N_CLASS-1:0]             raw_en, raw_bad;
  logic [SUM_W-1:0]               sum;
  logic                           div_start, div_done;
  logic [SLOT_W-1:0]              div_quot, div_rem;

  always_comb begin
    for (int l = 0; l < N_CLASS; l++) begin
      raw_en[l]  = |weight_i[l];
      raw_bad[l] = (|(weight_i[l] >> SLOT_W)) |
                   (raw_en[l] & ((window_i[l] == '0) | (|(window_i[l] >> WIN_W))));
    end
  end

  always_comb begin
    sum = '0;
    for (int l = 0; l < N_CLASS; l++) sum = sum + SUM_W'(w_q[l]);
  end

  assign div_start = (state_q == CFG_DIV_GO) && en_o[cls_q];

  sched_serial_div #(.W(SLOT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (hyper_len_o),
    .divisor_i  (w_q[cls_q]),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CFG_IDLE;
      cls_q       <= '0;
      w_q         <= '0;
      en_o        <= '0;
      window_o    <= '0;
      period_o    <= '0;
      hyper_len_o <= '0;
      err_o       <= 1'b0;
      ok_o        <= 1'b0;
    end else if (load_i) begin
      for (int l = 0; l < N_CLASS; l++) begin
        w_q[l]      <= weight_i[l][SLOT_W-1:0];
        window_o[l] <= window_i[l][WIN_W-1:0];
      end
      en_o    <= raw_en;
      err_o   <= |raw_bad;
      ok_o    <= 1'b0;
      state_q <= CFG_SUM;
    end else begin
      case (state_q)
        CFG_SUM: begin
          hyper_len_o <= sum[SLOT_W-1:0];
          if (sum == '0 || (|(sum >> SLOT_W))) err_o <= 1'b1;
          cls_q   <= '0;
          state_q <= CFG_DIV_GO;
        end
        CFG_DIV_GO: begin
          if (!en_o[cls_q]) begin
            period_o[cls_q] <= '0;
            if (cls_q == CLS_W'(N_CLASS - 1)) state_q <= CFG_DONE;
            else cls_q <= cls_q + 1'b1;
          end else begin
            state_q <= CFG_DIV_WAIT;
          end
        end
        CFG_DIV_WAIT: begin
          if (div_done) begin
            period_o[cls_q] <= div_quot;
            if (div_rem != '0) err_o <= 1'b1;
            if (cls_q == CLS_W'(N_CLASS - 1)) begin
              state_q <= CFG_DONE;
            end else begin
              cls_q   <= cls_q + 1'b1;
              state_q <= CFG_DIV_GO;
            end
          end
        end
        CFG_DONE: ok_o <= ~err_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sched_slot_engine.sv
module sched_slot_engine #(
  parameter int N_CLASS = 5,
  parameter int SLOT_W  = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           active_i,
  input  logic                           adv_i,
  input  logic [SLOT_W-1:0]              hyper_len_i,
  input  logic [N_CLASS-1:0][SLOT_W-1:0] period_i,
  input  logic [N_CLASS-1:0]             en_i,
  input  logic [N_CLASS-1:0]             gnt_oh_i,
  output logic [N_CLASS-1:0]             armed_o,
  output logic [SLOT_W-1:0]              slot_idx_o,
  output logic                           hyper_o
);
  logic wrap;
  assign wrap = (slot_idx_o == hyper_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_idx_o <= '0;
      hyper_o    <= 1'b0;
    end else if (!active_i) begin
      slot_idx_o <= '0;
      hyper_o    <= 1'b0;
    end else begin
      hyper_o <= adv_i & wrap;
      if (adv_i) slot_idx_o <= wrap ? '0 : slot_idx_o + 1'b1;
    end
  end

  for (genvar l = 0; l < N_CLASS; l++) begin : g_cls
    logic [SLOT_W-1:0] phase_q;
    logic              ready_q;

    // phase tracks slot_idx mod period; zero marks a re-arm point
    assign armed_o[l] = en_i[l] & (ready_q | (phase_q == '0));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        phase_q <= '0;
        ready_q <= 1'b0;
      end else if (!active_i) begin
        phase_q <= '0;
        ready_q <= 1'b0;
      end else if (adv_i) begin
        phase_q <= (wrap || phase_q == period_i[l] - 1'b1) ? '0 : phase_q + 1'b1;
        ready_q <= armed_o[l] & ~gnt_oh_i[l];
      end
    end
  end
endmodule

// File: rtl/sched_prio_pick.sv
module sched_prio_pick #(
  parameter int N_CLASS = 5,
  parameter int CLS_W   = 3
) (
  input  logic [N_CLASS-1:0] req_i,
  output logic               valid_o,
  output logic [CLS_W-1:0]   idx_o,
  output logic [N_CLASS-1:0] onehot_o
);
  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int l = 0; l < N_CLASS; l++) begin
      if (req_i[l] && !valid_o) begin
        valid_o     = 1'b1;
        idx_o       = CLS_W'(l);
        onehot_o[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/class_slot_sched.sv
module class_slot_sched #(
  parameter int N_CLASS = 5,
  parameter int CFG_W   = 32,
  parameter int SLOT_W  = 12,
  parameter int WIN_W   = 8,
  localparam int CLS_W  = (N_CLASS > 1) ? $clog2(N_CLASS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_load_i,
  input  logic [N_CLASS-1:0][CFG_W-1:0] weight_cfg_i,
  input  logic [N_CLASS-1:0][CFG_W-1:0] window_cfg_i,
  input  logic                          slot_done_i,
  output logic                          grant_valid_o,
  output logic [CLS_W-1:0]              grant_class_o,
  output logic [WIN_W-1:0]              grant_window_o,
  output logic [SLOT_W-1:0]             slot_idx_o,
  output logic                          hyper_start_o,
  output logic                          active_o,
  output logic                          cfg_err_o
);
  logic [SLOT_W-1:0]              hyper_len;
  logic [N_CLASS-1:0][SLOT_W-1:0] period;
  logic [N_CLASS-1:0][WIN_W-1:0]  win;
  logic [N_CLASS-1:0]             cls_en, armed, gnt_oh;
  logic                           pick_valid, adv, hyper_q;
  logic [CLS_W-1:0]               pick_idx;

  sched_cfg_calc #(
    .N_CLASS(N_CLASS), .CFG_W(CFG_W), .SLOT_W(SLOT_W), .WIN_W(WIN_W), .CLS_W(CLS_W)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_load_i),
    .weight_i    (weight_cfg_i),
    .window_i    (window_cfg_i),
    .ok_o        (active_o),
    .err_o       (cfg_err_o),
    .hyper_len_o (hyper_len),
    .period_o    (period),
    .en_o        (cls_en),
    .window_o    (win)
  );

  sched_prio_pick #(.N_CLASS(N_CLASS), .CLS_W(CLS_W)) u_pick (
    .req_i    (armed),
    .valid_o  (pick_valid),
    .idx_o    (pick_idx),
    .onehot_o (gnt_oh)
  );

  // idle slots step on their own; granted slots wait for the lower tier
  assign adv = active_o & (pick_valid ? slot_done_i : 1'b1);

  sched_slot_engine #(.N_CLASS(N_CLASS), .SLOT_W(SLOT_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active_o),
    .adv_i       (adv),
    .hyper_len_i (hyper_len),
    .period_i    (period),
    .en_i        (cls_en),
    .gnt_oh_i    (gnt_oh),
    .armed_o     (armed),
    .slot_idx_o  (slot_idx_o),
    .hyper_o     (hyper_q)
  );

  assign grant_valid_o  = active_o & pick_valid;
  assign grant_class_o  = pick_idx;
  assign grant_window_o = grant_valid_o ? win[pick_idx] : '0;
  assign hyper_start_o  = hyper_q & active_o;
endmodule

// File: rtl/class_slot_sched_chk.sv
module class_slot_sched_chk #(
  parameter int N_CLASS = 5,
  parameter int SLOT_W  = 12,
  parameter int CLS_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_load_i,
  input logic               slot_done_i,
  input logic               grant_valid_o,
  input logic [CLS_W-1:0]   grant_class_o,
  input logic [SLOT_W-1:0]  slot_idx_o,
  input logic               hyper_start_o,
  input logic               active_o,
  input logic               cfg_err_o,
  input logic [SLOT_W-1:0]  hyper_len,
  input logic [N_CLASS-1:0] cls_en
);
  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> slot_idx_o < hyper_len);

  assert_hyper_at_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hyper_start_o |-> (slot_idx_o == '0) && active_o);

  assert_class_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> {1'b0, grant_class_o} < (CLS_W + 1)'(N_CLASS));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && grant_valid_o && !slot_done_i && !cfg_load_i
    |=> $stable(slot_idx_o) && grant_valid_o && $stable(grant_class_o));

  assert_idle_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !grant_valid_o && !cfg_load_i |=> slot_idx_o != $past(slot_idx_o));

  assert_err_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !active_o && !grant_valid_o);

  assert_grant_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> cls_en[grant_class_o]);
endmodule

bind class_slot_sched class_slot_sched_chk #(
  .N_CLASS(N_CLASS), .SLOT_W(SLOT_W), .CLS_W(CLS_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_load_i    (cfg_load_i),
  .slot_done_i   (slot_done_i),
  .grant_valid_o (grant_valid_o),
  .grant_class_o (grant_class_o),
  .slot_idx_o    (slot_idx_o),
  .hyper_start_o (hyper_start_o),
  .active_o      (active_o),
  .cfg_err_o     (cfg_err_o),
  .hyper_len     (hyper_len),
  .cls_en        (cls_en)
);

// File: tb/class_slot_sched_bench.sv
module class_slot_sched_bench;
  localparam int N = 5;
  localparam int CW = 32;
  localparam int SW = 12;
  localparam int ZW = 8;
  localparam int CLW = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_load_i = 1'b0;
  logic [N-1:0][CW-1:0] weight_cfg_i = '0;
  logic [N-1:0][CW-1:0] window_cfg_i = '0;
  logic              slot_done_i = 1'b0;
  logic              grant_valid_o;
  logic [CLW-1:0]    grant_class_o;
  logic [ZW-1:0]     grant_window_o;
  logic [SW-1:0]     slot_idx_o;
  logic              hyper_start_o;
  logic              active_o;
  logic              cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  class_slot_sched #(.N_CLASS(N), .CFG_W(CW), .SLOT_W(SW), .WIN_W(ZW)) u_class_slot_sched (
    .clk_i, .rst_ni, .cfg_load_i, .weight_cfg_i, .window_cfg_i, .slot_done_i,
    .grant_valid_o, .grant_class_o, .grant_window_o, .slot_idx_o,
    .hyper_start_o, .active_o, .cfg_err_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit exp_err(input int w[N], input int z[N]);
    int h = 0;
    bit e = 0;
    for (int l = 0; l < N; l++) begin
      if (w[l] < 0 || w[l] >= (1 << SW)) e = 1;
      if (w[l] != 0 && (z[l] <= 0 || z[l] >= (1 << ZW))) e = 1;
      h += w[l];
    end
    if (h <= 0 || h >= (1 << SW)) e = 1;
    for (int l = 0; l < N; l++)
      if (!e && w[l] != 0 && (h % w[l]) != 0) e = 1;
    return e;
  endfunction

  // load a parameter set, then compare against the modulo re-arm model
  task automatic run_cfg(input int w[N], input int z[N], input int ncyc, input bit rnd);
    int h = 0;
    int slot = 0;
    int cnt = 0;
    bit hyp = 0;
    bit cg[N];
    bit tmp[N];
    bit e;
    bit seen;
    e = exp_err(w, z);
    for (int l = 0; l < N; l++) begin
      weight_cfg_i[l] = w[l];
      window_cfg_i[l] = z[l];
      h += w[l];
      cg[l] = 1;
    end
    cfg_load_i = 1'b1;
    @(negedge clk_i);
    cfg_load_i = 1'b0;
    seen = 0;
    for (int t = 0; t < 300 && !seen; t++) begin
      @(negedge clk_i);
      if (active_o || cfg_err_o) seen = 1;
      else check(!grant_valid_o, "R9 valid low while computing", grant_valid_o, 0);
    end
    check(cfg_err_o == e, "R7 error flag", cfg_err_o, e);
    check(active_o == !e, "R7 R9 active", active_o, !e);
    if (e || !active_o) begin
      for (int t = 0; t < 4; t++) begin
        @(negedge clk_i);
        check(!grant_valid_o && !active_o, "R7 stopped on bad set", grant_valid_o, 0);
      end
      return;
    end
    check(slot_idx_o == 0, "R9 start slot", slot_idx_o, 0);
    for (int c = 0; c < ncyc; c++) begin
      int g = -1;
      bit dn, adv;
      for (int l = 0; l < N; l++) begin
        tmp[l] = cg[l];
        if (w[l] != 0 && (slot % (h / w[l])) == 0) tmp[l] = 0; // R2 re-arm
      end
      for (int l = 0; l < N; l++)
        if (g < 0 && w[l] != 0 && !tmp[l]) g = l;                // R3 priority
      check(grant_valid_o == (g >= 0), "R3 R6 valid", grant_valid_o, g >= 0);
      if (g >= 0) begin
        check(grant_class_o == g, "R2 R3 class", grant_class_o, g);
        check(grant_window_o == z[g], "R4 window", grant_window_o, z[g]);
        check(w[grant_class_o] != 0, "R8 disabled class granted", grant_class_o, g);
      end
      check(slot_idx_o == slot, "R1 R5 R6 slot index", slot_idx_o, slot);
      check(hyper_start_o == hyp, "R1 hyperperiod pulse", hyper_start_o, hyp);
      if (rnd) dn = ($urandom % 3) == 0;
      else dn = (g >= 0) && (cnt == z[g] - 1);
      adv = (g < 0) || dn;
      slot_done_i = dn;
      if (adv) begin
        if (g >= 0) tmp[g] = 1;
        for (int l = 0; l < N; l++) cg[l] = tmp[l];
        hyp = (slot == h - 1);
        slot = (slot + 1) % h;
        cnt = 0;
      end else begin
        hyp = 0;
        cnt++;
      end
      @(negedge clk_i);
    end
    slot_done_i = 1'b0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int ws[4] = '{0, 1, 2, 4};
    repeat (3) @(negedge clk_i);
    check(!active_o && !grant_valid_o && !hyper_start_o && !cfg_err_o && slot_idx_o == 0,
          "R10 reset state", {active_o, grant_valid_o, hyper_start_o, cfg_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!active_o && !grant_valid_o, "R10 idle after reset", active_o, 0);

    run_cfg('{2, 2, 4, 0, 0}, '{2, 3, 3, 1, 1}, 80, 0);
    run_cfg('{2, 2, 4, 0, 0}, '{2, 3, 3, 1, 1}, 80, 1);
    run_cfg('{1, 1, 1, 1, 1}, '{1, 2, 3, 4, 5}, 60, 0);
    run_cfg('{4, 2, 1, 1, 0}, '{3, 1, 2, 2, 9}, 60, 1);
    run_cfg('{1, 1, 2, 4, 8}, '{1, 1, 1, 2, 1}, 120, 1);
    run_cfg('{0, 0, 0, 0, 8}, '{0, 0, 0, 0, 255}, 40, 1);
    run_cfg('{3, 2, 0, 0, 0}, '{1, 1, 1, 1, 1}, 10, 1);
    run_cfg('{2, 2, 0, 0, 0}, '{1, 0, 1, 1, 1}, 10, 1);
    run_cfg('{2, 2, 0, 0, 0}, '{1, 256, 1, 1, 1}, 10, 1);
    run_cfg('{32'h0001_0002, 2, 0, 0, 0}, '{1, 1, 1, 1, 1}, 10, 1);
    run_cfg('{0, 0, 0, 0, 0}, '{1, 1, 1, 1, 1}, 10, 1);

    // sweep three classes over weights {0,1,2,4}
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          run_cfg('{ws[a], ws[b], ws[c], 0, 0}, '{a + 1, b + 2, c + 1, 1, 1}, 40, 1);

    // load mid-schedule restarts at slot 0
    run_cfg('{1, 1, 2, 0, 0}, '{2, 2, 2, 1, 1}, 7, 1);
    run_cfg('{2, 1, 1, 0, 0}, '{1, 1, 3, 1, 1}, 30, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule